// File: doc/BRIEF.md
# Planar Pixel Formatter with Palette

This block sits in the graphics refresh path, one stage after the memory read. Once per character clock it takes a 32-bit word that holds one byte from each of four bit planes. It breaks the word into a stream of pixels at the dot clock, using one of three graphics layouts: odd/even paired 4-bit, planar 4-bit, or packed 8-bit. Each pixel is then turned into an 8-bit index for the colour lookup DAC.

For the 4-bit layouts, a plane-enable mask clears selected pixel bits first. The result addresses a 16-entry table of 6-bit colours, and a 2-bit colour-select value sits above the table output. For the packed layout, the table is skipped and the pixel byte goes out unchanged. Each packed pixel is shown for two dot clocks, so every layout fills eight dot clocks per word. Software loads the table through a simple write port.

Top module: `planar_pixel_fmt`

## Requirements
- R1: After reset, pix_valid_o is 0, dac_idx_o is 0 and every palette entry is 0.
- R2: A word is accepted on a clock edge where dword_valid_i is 1. Pixel k (k = 0..7) of that word appears on dac_idx_o, with pix_valid_o = 1, in the (k+1)-th cycle after the accepting edge. A word accepted before the eight pixels are done starts a new sequence at once, and the rest of the old word is dropped. When no pixel is being sent, pix_valid_o is 0 and dac_idx_o is 0.
- R3: Plane p is held in dword_i[8p+7:8p]. In odd/even format (fmt 00), pixel i (i = 0..3) takes bits [3:2] from plane 2 and bits [1:0] from plane 0. Pixel 4+i takes the same bits from planes 3 and 1. The 2-bit fields are read from each byte most significant pair first.
- R4: In planar format (fmt 01), pixel k has bit p equal to bit 7-k of plane p.
- R5: In packed format (fmt 10 or 11), the word gives four pixels: plane 0, then 1, then 2, then 3. Each pixel is sent on two dot clocks in a row. dac_idx_o equals the pixel byte, and plane_en_i, color_sel_i and the palette have no effect.
- R6: In the 4-bit formats, the palette address is the pixel value ANDed with plane_en_i. Bit n of plane_en_i keeps pixel bit n. The mask value used is the one present in the cycle before the pixel appears.
- R7: A palette write (pal_we_i, pal_addr_i, pal_data_i) updates the entry at the clock edge. A pixel that is looked up at that same edge gets the entry's old value.
- R8: In the 4-bit formats, dac_idx_o[7:6] equals color_sel_i and dac_idx_o[5:0] equals the palette entry. Both are taken from the cycle before the pixel appears.
- R9: The format is captured together with the word. A change on fmt_i while a word is being sent has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dword_valid_i | input | 1 | Accept dword_i at this edge |
| dword_i | input | 32 | Four plane bytes, plane p in bits [8p+7:8p] |
| fmt_i | input | 2 | 00 odd/even, 01 planar, 1x packed 8-bit |
| plane_en_i | input | 4 | Pixel bit mask applied before the palette |
| color_sel_i | input | 2 | Upper two index bits in the 4-bit formats |
| pal_we_i | input | 1 | Palette write strobe |
| pal_addr_i | input | 4 | Palette write address |
| pal_data_i | input | 6 | Palette write data |
| pix_valid_o | output | 1 | A pixel is present on dac_idx_o |
| dac_idx_o | output | 8 | DAC index for the current dot |

## Verification
Two events can fall in the same cycle: a palette write and a lookup of that same entry by a pixel that is being sent. The bench sets up this collision in two ways. First, it rewrites the entries while a stream of 4-bit pixels runs, with a mask that reduces every pixel to a few addresses. Second, it sends random write traffic along with continuous words. The reference model runs the lookup before it applies the write, so any pixel that sees the new value one cycle early shows up as a mismatch on dac_idx_o. A second overlap is a new word arriving while the last pixels of the previous word are still being sent. This is tested with early, back-to-back and gapped word timings.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  localparam int PLANES  = 4;
  localparam int PLANE_W = 8;
  localparam int SLOTS   = 8;

  typedef enum logic [1:0] {
    FMT_ODD_EVEN = 2'b00,
    FMT_PLANAR   = 2'b01,
    FMT_PACKED   = 2'b10,
    FMT_PACKED_A = 2'b11
  } fmt_e;
endpackage

// File: rtl/ppf_unpack.sv
module ppf_unpack
  import ppf_pkg::*;
(
  input  logic [PLANES*PLANE_W-1:0]       dword_i,
  input  logic [1:0]                      fmt_i,
  output logic [SLOTS-1:0][PLANE_W-1:0]   pix_o
);
  localparam int HALF = SLOTS / 2;

  logic [SLOTS-1:0][PLANE_W-1:0] pix_oe, pix_pl, pix_pk;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int SH = PLANE_W - 2 - 2 * (k % HALF);
    localparam int HI = (k < HALF) ? 2 : 3;
    localparam int LO = (k < HALF) ? 0 : 1;

    // odd/even: paired planes, 2-bit fields
    assign pix_oe[k] = {{(PLANE_W-4){1'b0}},
                        dword_i[HI*PLANE_W+SH +: 2],
                        dword_i[LO*PLANE_W+SH +: 2]};

    // planar: one bit per plane
    for (genvar p = 0; p < PLANES; p++) begin : g_pl
      assign pix_pl[k][p] = dword_i[p*PLANE_W + PLANE_W-1-k];
    end
    assign pix_pl[k][PLANE_W-1:PLANES] = '0;

    // packed: byte per pixel, each doubled
    assign pix_pk[k] = dword_i[(k/2)*PLANE_W +: PLANE_W];
  end

  always_comb begin
    unique case (fmt_i)
      FMT_ODD_EVEN: pix_o = pix_oe;
      FMT_PLANAR:   pix_o = pix_pl;
      default:      pix_o = pix_pk;
    endcase
  end
endmodule

// File: rtl/ppf_serializer.sv
module ppf_serializer #(
  parameter int SLOTS = 8,
  parameter int PIX_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [SLOTS-1:0][PIX_W-1:0] pix_i,
  input  logic                        wide_i,
  output logic                        busy_o,
  output logic [PIX_W-1:0]            pix_o,
  output logic                        wide_o
);
  localparam int CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [SLOTS-1:0][PIX_W-1:0] buf_q;
  logic [CNT_W-1:0]            cnt_q;
  logic                        busy_q, wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      wide_q <= 1'b0;
    end else if (load_i) begin
      buf_q  <= pix_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      wide_q <= wide_i;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign pix_o  = buf_q[cnt_q];
  assign wide_o = wide_q;

  // R2: slots step one per dot clock until the last
  a_r2_slot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R2: a new word restarts the sequence
  a_r2_load_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/ppf_palette.sv
module ppf_palette #(
  parameter int DEPTH = 16,
  parameter int PAL_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [PAL_W-1:0]         wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [PAL_W-1:0]         rdata_o
);
  logic [PAL_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read sees pre-write contents at a write edge
  assign rdata_o = mem_q[raddr_i];

  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/planar_pixel_fmt.sv
module planar_pixel_fmt
  import ppf_pkg::*;
#(
  parameter int PAL_DEPTH = 16,
  parameter int PAL_W     = 6,
  parameter int DAC_W     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dword_valid_i,
  input  logic [PLANES*PLANE_W-1:0] dword_i,
  input  logic [1:0]                fmt_i,
  input  logic [PLANES-1:0]         plane_en_i,
  input  logic [DAC_W-PAL_W-1:0]    color_sel_i,
  input  logic                      pal_we_i,
  input  logic [3:0]                pal_addr_i,
  input  logic [PAL_W-1:0]          pal_data_i,
  output logic                      pix_valid_o,
  output logic [DAC_W-1:0]          dac_idx_o
);
  localparam int AW = $clog2(PAL_DEPTH);

  logic [SLOTS-1:0][PLANE_W-1:0] unp;
  logic                          busy, wide;
  logic [PLANE_W-1:0]            cur_pix;
  logic [AW-1:0]                 pal_raddr;
  logic [PAL_W-1:0]              pal_rdata;
  logic                          vld_q;
  logic [DAC_W-1:0]              dac_q;

  ppf_unpack u_unpack (
    .dword_i (dword_i),
    .fmt_i   (fmt_i),
    .pix_o   (unp)
  );

  ppf_serializer #(.SLOTS(SLOTS), .PIX_W(PLANE_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dword_valid_i),
    .pix_i  (unp),
    .wide_i (fmt_i[1]),
    .busy_o (busy),
    .pix_o  (cur_pix),
    .wide_o (wide)
  );

  assign pal_raddr = AW'(cur_pix[PLANES-1:0] & plane_en_i);

  ppf_palette #(.DEPTH(PAL_DEPTH), .PAL_W(PAL_W)) u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we_i),
    .waddr_i (pal_addr_i[AW-1:0]),
    .wdata_i (pal_data_i),
    .raddr_i (pal_raddr),
    .rdata_o (pal_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dac_q <= '0;
    end else begin
      vld_q <= busy;
      if (!busy)     dac_q <= '0;
      else if (wide) dac_q <= DAC_W'(cur_pix);
      else           dac_q <= {color_sel_i, pal_rdata};
    end
  end

  assign pix_valid_o = vld_q;
  assign dac_idx_o   = dac_q;

  a_r8_color_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !wide) |=> dac_idx_o[DAC_W-1:PAL_W] == $past(color_sel_i));

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> (!pix_valid_o && dac_idx_o == '0));
endmodule

// File: tb/tb_planar_pixel_fmt.sv
`timescale 1ns/1ps
module tb_planar_pixel_fmt;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dword_valid_i = 1'b0;
  logic [31:0] dword_i = '0;
  logic [1:0]  fmt_i = '0;
  logic [3:0]  plane_en_i = 4'hF;
  logic [1:0]  color_sel_i = '0;
  logic        pal_we_i = 1'b0;
  logic [3:0]  pal_addr_i = '0;
  logic [5:0]  pal_data_i = '0;
  logic        pix_valid_o;
  logic [7:0]  dac_idx_o;

  always #4 clk = ~clk;

  planar_pixel_fmt dut (
    .clk_i(clk), .rst_ni(rst_ni), .dword_valid_i(dword_valid_i), .dword_i(dword_i),
    .fmt_i(fmt_i), .plane_en_i(plane_en_i), .color_sel_i(color_sel_i),
    .pal_we_i(pal_we_i), .pal_addr_i(pal_addr_i), .pal_data_i(pal_data_i),
    .pix_valid_o(pix_valid_o), .dac_idx_o(dac_idx_o)
  );

  int    checks = 0, fails = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int         m_pix [8];
  int         m_cnt = 0;
  bit         m_busy = 0, m_wide = 0;
  logic [5:0] m_pal [16];
  logic       e_vld = 0;
  logic [7:0] e_dac = 0;

  function automatic int unpack(input logic [31:0] d, input logic [1:0] f, input int k);
    int v;
    v = 0;
    if (f[1]) begin
      v = int'((d >> (8 * (k / 2))) & 32'hFF);
    end else if (f == 2'b01) begin
      for (int p = 0; p < 4; p++) v |= int'((d >> (8 * p + 7 - k)) & 1) << p;
    end else begin
      int hi, lo, sh;
      hi = (k < 4) ? 2 : 3;
      lo = (k < 4) ? 0 : 1;
      sh = 6 - 2 * (k % 4);
      v = (int'((d >> (8 * hi + sh)) & 3) << 2) | int'((d >> (8 * lo + sh)) & 3);
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_cnt = 0; m_wide = 0;
      for (int i = 0; i < 16; i++) m_pal[i] = '0;
      e_vld <= 0; e_dac <= 0;
    end else begin
      logic [7:0] px;
      px = 8'(m_pix[m_cnt]);
      e_vld <= m_busy;
      if (!m_busy)     e_dac <= 0;
      else if (m_wide) e_dac <= px;
      else             e_dac <= {color_sel_i, m_pal[px[3:0] & plane_en_i]};
      if (pal_we_i) m_pal[pal_addr_i] = pal_data_i;
      if (dword_valid_i) begin
        for (int k = 0; k < 8; k++) m_pix[k] = unpack(dword_i, fmt_i, k);
        m_cnt = 0; m_busy = 1; m_wide = fmt_i[1];
      end else if (m_busy) begin
        if (m_cnt == 7) m_busy = 0;
        else            m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      checks++;
      if (pix_valid_o !== e_vld || dac_idx_o !== e_dac) begin
        fails++;
        $display("FAIL %s: valid=%0b dac=%02h expected valid=%0b dac=%02h",
                 cur_req, pix_valid_o, dac_idx_o, e_vld, e_dac);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(input logic [31:0] d, input logic [1:0] f);
    @(negedge clk);
    dword_valid_i = 1; dword_i = d; fmt_i = f;
    @(negedge clk);
    dword_valid_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stream(input logic [31:0] d, input logic [1:0] f);
    send(d, f);
    idle(6);
  endtask

  initial begin
    idle(3);
    // R1: outputs held at zero in reset
    checks++;
    if (pix_valid_o !== 0 || dac_idx_o !== 0) begin
      fails++;
      $display("FAIL R1: valid=%0b dac=%02h expected 0/00", pix_valid_o, dac_idx_o);
    end
    @(negedge clk); rst_ni = 1;

    // R1: palette all zero, color_sel 0 -> index 0
    cur_req = "R1";
    stream(32'hA5C3_5A3C, 2'b01);
    idle(2);

    // R7: load palette
    cur_req = "R7";
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      pal_we_i = 1; pal_addr_i = 4'(i); pal_data_i = 6'((i * 23 + 5) & 63);
    end
    @(negedge clk); pal_we_i = 0;

    cur_req = "R4";
    stream(32'hF0CC_AA55, 2'b01);
    stream(32'h0F33_55AA, 2'b01);
    idle(3);

    cur_req = "R3";
    stream(32'hE41B_9C63, 2'b00);
    stream(32'h1BE4_639C, 2'b00);
    idle(2);

    cur_req = "R6";
    plane_en_i = 4'b0011;
    send(32'hFFAA_5500, 2'b01);
    idle(3); plane_en_i = 4'b1010; idle(4);
    plane_en_i = 4'hF;

    cur_req = "R8";
    color_sel_i = 2'b10;
    send(32'h1234_5678, 2'b00);
    idle(3); color_sel_i = 2'b01; idle(5);

    cur_req = "R5";
    plane_en_i = 4'b0000; color_sel_i = 2'b11;
    stream(32'h8040_2010, 2'b10);
    stream(32'hFEDC_BA98, 2'b11);
    plane_en_i = 4'hF; color_sel_i = 0;
    idle(2);

    cur_req = "R9";
    send(32'hC3C3_3C3C, 2'b01);
    fmt_i = 2'b10; idle(3); fmt_i = 2'b00; idle(4);
    idle(2);

    cur_req = "R2";
    send(32'h1111_2222, 2'b01);
    idle(2);
    send(32'h8765_4321, 2'b00);
    send(32'hDEAD_BEEF, 2'b10);
    idle(12);

    // R7: rewrite entries while pixels look them up
    cur_req = "R7";
    plane_en_i = 4'b0001;
    send(32'h00FF_00AA, 2'b01);
    for (int i = 0; i < 7; i++) begin
      pal_we_i = 1; pal_addr_i = 4'(i & 1); pal_data_i = 6'(i * 9 + 1);
      @(negedge clk);
    end
    pal_we_i = 0; plane_en_i = 4'hF;
    idle(3);

    // R2 R3 R4 R5 R6 R7 R8: mixed random traffic
    cur_req = "R2/R7 mixed";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      dword_valid_i = ($urandom % 5) == 0;
      dword_i = $urandom;
      fmt_i = 2'($urandom);
      pal_we_i = ($urandom % 3) == 0;
      pal_addr_i = 4'($urandom);
      pal_data_i = 6'($urandom);
      plane_en_i = 4'($urandom);
      color_sel_i = 2'($urandom);
    end
    @(negedge clk);
    dword_valid_i = 0; pal_we_i = 0;
    idle(12);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule